// File: doc/BRIEF.md
# Register-File ALU Datapath

This block is the execution datapath of a register-organised processor. It holds seven general registers of parameterised width. One packed 14-bit control word steers it for a whole clock cycle. Two source selectors each place either a register or the external data input onto an operand bus. A shared ALU combines the two buses. The ALU result is always driven on the external output. On the next rising clock edge it can also be written into one register, which a destination decoder chooses.

A sequencer outside the block supplies one control word per cycle. A micro-operation such as "R1 gets R2 plus R3" completes in a single clock. Code zero has a different meaning on each side of the datapath. As a source, it takes the external input. As a destination, it writes no register, so the result is only visible on the output. The control word and the data are plain per-cycle pins, with no valid/ready handshake, because every word is consumed in the cycle it is presented and the block cannot apply back-pressure.

Top module: `regalu_datapath`

## Requirements
- R1: The control word is split into four fields: source A in bits [13:11], source B in bits [10:8], destination in bits [7:5], and ALU operation in bits [4:0].
- R2: For each source field, code 0 selects `ext_in` and codes 1 to 7 select registers R1 to R7. Both operand buses follow this rule independently, and both may name the same source.
- R3: A destination code of 1 to 7 writes the ALU result into that register at the rising clock edge. All other registers keep their values.
- R4: A destination code of 0 writes no register, but the ALU result is still driven on `ext_out`.
- R5: `ext_out` is a combinational function of the current control word, `ext_in` and the register contents. It settles within the same cycle.
- R6: The arithmetic operation codes are: 1 = A+1, 2 = A+B, 3 = A−B, 4 = A−1. All of them wrap modulo 2^DATA_W.
- R7: The logic operation codes are: 5 = A AND B, 6 = A OR B, 7 = A XOR B, 8 = NOT A.
- R8: Code 9 shifts A right by one bit and code 10 shifts A left by one bit. Both shifts fill the vacated bit with zero and drop the bit shifted out.
- R9: Operation code 0 passes A to the output unchanged. Every unused code (11 to 31) also passes A.
- R10: When one control word both reads and writes the same register, the output is computed from the value the register held before the edge.
- R11: An active-low reset clears all seven registers to zero. The reset acts asynchronously and blocks writes while it is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers load on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 14 | Packed source A, source B, destination and operation fields |
| ext_in | input | DATA_W | External operand, selected by source code 0 |
| ext_out | output | DATA_W | ALU result of the current control word |

## Verification
A vector table first loads registers from the external input. It then runs every operation code on operand values chosen so that each result differs from the results of the neighbouring codes. A swapped field, a mis-decoded opcode or a bus that takes the wrong source therefore gives a wrong output byte. Dedicated rows drive the carry and borrow boundaries: increment from all-ones, decrement from zero, and a left shift that loses the top bit. Other rows run unused opcodes, same-register read-and-write words, and words with the destination code zero. After each of these rows the stored registers are read back through the external output, which shows whether a write landed, was dropped, or hit the wrong register. Finally, reset is applied in the middle of a run, and the bench confirms that it clears the registers and that it blocks a write while it is held.

// File: rtl/regalu_pkg.sv
package regalu_pkg;
  localparam int SEL_W  = 3;
  localparam int OP_W   = 5;
  localparam int CW_W   = 2 * SEL_W + SEL_W + OP_W;
  localparam int NREG   = (1 << SEL_W) - 1;

  typedef enum logic [OP_W-1:0] {
    OP_PASS = 5'd0,
    OP_INC  = 5'd1,
    OP_ADD  = 5'd2,
    OP_SUB  = 5'd3,
    OP_DEC  = 5'd4,
    OP_AND  = 5'd5,
    OP_OR   = 5'd6,
    OP_XOR  = 5'd7,
    OP_NOT  = 5'd8,
    OP_SHR  = 5'd9,
    OP_SHL  = 5'd10
  } alu_op_e;

  typedef struct packed {
    logic [SEL_W-1:0] src_a;
    logic [SEL_W-1:0] src_b;
    logic [SEL_W-1:0] dst;
    logic [OP_W-1:0]  op;
  } ctrl_word_t;
endpackage

// File: rtl/regalu_src_mux.sv
module regalu_src_mux #(
  parameter int W     = 8,
  parameter int SEL_W = 3,
  parameter int NREG  = 7
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [W-1:0]      ext_data,
  input  logic [NREG*W-1:0] regs_flat,
  output logic [W-1:0]      bus
);
  // code 0 = external input, code k = register k (stored at slot k-1)
  always_comb begin
    bus = ext_data;
    for (int k = 1; k <= NREG; k++) begin
      if (sel == SEL_W'(k)) bus = regs_flat[(k-1)*W +: W];
    end
  end
endmodule

// File: rtl/regalu_dest_dec.sv
module regalu_dest_dec #(
  parameter int SEL_W = 3,
  parameter int NREG  = 7
) (
  input  logic [SEL_W-1:0] dst,
  output logic [NREG-1:0]  wr_en
);
  // code 0 enables nothing; code k enables slot k-1
  for (genvar k = 0; k < NREG; k++) begin : g_dec
    assign wr_en[k] = (dst == SEL_W'(k + 1));
  end
endmodule

// File: rtl/regalu_alu.sv
module regalu_alu
  import regalu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    y
);
  always_comb begin
    case (op)
      OP_INC:  y = a + W'(1);
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_DEC:  y = a - W'(1);
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOT:  y = ~a;
      OP_SHR:  y = {1'b0, a[W-1:1]};
      OP_SHL:  y = {a[W-2:0], 1'b0};
      default: y = a;            // OP_PASS and every unused code
    endcase
  end
endmodule

// File: rtl/regalu_regfile.sv
module regalu_regfile #(
  parameter int W    = 8,
  parameter int NREG = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREG-1:0]   wr_en,
  input  logic [W-1:0]      wr_data,
  output logic [NREG*W-1:0] regs_flat
);
  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (wr_en[k]) q <= wr_data;
    end
    assign regs_flat[k*W +: W] = q;
  end
endmodule

// File: rtl/regalu_datapath.sv
module regalu_datapath
  import regalu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW_W-1:0]   ctrl_word,
  input  logic [DATA_W-1:0] ext_in,
  output logic [DATA_W-1:0] ext_out
);
  ctrl_word_t               cw;
  logic [DATA_W-1:0]        bus_a, bus_b, alu_y;
  logic [NREG-1:0]          wr_en;
  logic [NREG*DATA_W-1:0]   regs_flat;

  assign cw = ctrl_word_t'(ctrl_word);

  regalu_src_mux #(.W(DATA_W), .SEL_W(SEL_W), .NREG(NREG)) u_mux_a (
    .sel(cw.src_a), .ext_data(ext_in), .regs_flat(regs_flat), .bus(bus_a));

  regalu_src_mux #(.W(DATA_W), .SEL_W(SEL_W), .NREG(NREG)) u_mux_b (
    .sel(cw.src_b), .ext_data(ext_in), .regs_flat(regs_flat), .bus(bus_b));

  regalu_alu #(.W(DATA_W)) u_alu (
    .op(cw.op), .a(bus_a), .b(bus_b), .y(alu_y));

  regalu_dest_dec #(.SEL_W(SEL_W), .NREG(NREG)) u_dec (
    .dst(cw.dst), .wr_en(wr_en));

  regalu_regfile #(.W(DATA_W), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(alu_y),
    .regs_flat(regs_flat));

  assign ext_out = alu_y;
endmodule

// File: rtl/regalu_checker.sv
module regalu_checker #(
  parameter int W     = 8,
  parameter int SEL_W = 3,
  parameter int NREG  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SEL_W-1:0]  sel_a,
  input logic [SEL_W-1:0]  sel_b,
  input logic [SEL_W-1:0]  sel_d,
  input logic [W-1:0]      ext_in,
  input logic [W-1:0]      bus_a,
  input logic [W-1:0]      bus_b,
  input logic [NREG-1:0]   wr_en,
  input logic [NREG*W-1:0] regs_flat,
  input logic [W-1:0]      alu_y
);
  AST_SRC_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == '0) |-> (bus_a == ext_in)); // R2

  AST_SAME_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == sel_b) |-> (bus_a == bus_b)); // R2

  AST_DEC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en)); // R3

  AST_NONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_d == '0) |=> $stable(regs_flat)); // R4

  for (genvar k = 0; k < NREG; k++) begin : g_slot
    AST_DEST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_d == SEL_W'(k + 1)) |=> (regs_flat[k*W +: W] == $past(alu_y))); // R3

    AST_OTHER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_d != SEL_W'(k + 1)) |=> $stable(regs_flat[k*W +: W])); // R3
  end
endmodule

bind regalu_datapath regalu_checker #(.W(DATA_W), .SEL_W(regalu_pkg::SEL_W), .NREG(regalu_pkg::NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_a(cw.src_a), .sel_b(cw.src_b), .sel_d(cw.dst),
  .ext_in(ext_in), .bus_a(bus_a), .bus_b(bus_b), .wr_en(wr_en),
  .regs_flat(regs_flat), .alu_y(alu_y));

// File: tb/sim_regalu_datapath.sv
module sim_regalu_datapath;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] ctrl_word = '0;
  logic [7:0]  ext_in = '0;
  logic [7:0]  ext_out;
  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  regalu_datapath #(.DATA_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .ext_in(ext_in), .ext_out(ext_out));

  typedef struct packed {
    logic [13:0] cw;
    logic [7:0]  din;
    logic [7:0]  exp;
    logic [3:0]  req;
  } vec_t;

  // {srcA, srcB, dst, op}
  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    '{{3'd0,3'd0,3'd1,5'd0 }, 8'h35, 8'h35, 4'd2 },  // R2 R1<-ext
    '{{3'd0,3'd0,3'd2,5'd0 }, 8'h0C, 8'h0C, 4'd1 },  // R1 R2<-ext
    '{{3'd1,3'd2,3'd3,5'd2 }, 8'h00, 8'h41, 4'd6 },  // R6 add
    '{{3'd1,3'd2,3'd4,5'd3 }, 8'h00, 8'h29, 4'd6 },  // R6 sub
    '{{3'd2,3'd1,3'd5,5'd3 }, 8'h00, 8'hD7, 4'd6 },  // R6 sub borrow
    '{{3'd1,3'd5,3'd6,5'd5 }, 8'h00, 8'h15, 4'd7 },  // R7 and
    '{{3'd1,3'd2,3'd7,5'd6 }, 8'h00, 8'h3D, 4'd7 },  // R7 or
    '{{3'd1,3'd7,3'd1,5'd7 }, 8'h00, 8'h08, 4'd10},  // R10 xor into src
    '{{3'd2,3'd0,3'd2,5'd8 }, 8'hAA, 8'hF3, 4'd7 },  // R7 not
    '{{3'd3,3'd0,3'd3,5'd9 }, 8'h00, 8'h20, 4'd8 },  // R8 shr
    '{{3'd4,3'd0,3'd4,5'd10}, 8'h00, 8'h52, 4'd8 },  // R8 shl
    '{{3'd5,3'd0,3'd5,5'd1 }, 8'h00, 8'hD8, 4'd6 },  // R6 inc
    '{{3'd6,3'd0,3'd6,5'd4 }, 8'h00, 8'h14, 4'd6 },  // R6 dec
    '{{3'd7,3'd0,3'd0,5'd2 }, 8'h03, 8'h40, 4'd4 },  // R4 output only
    '{{3'd7,3'd0,3'd0,5'd0 }, 8'h00, 8'h3D, 4'd4 },  // R4 R7 untouched
    '{{3'd0,3'd0,3'd2,5'd0 }, 8'hFF, 8'hFF, 4'd3 },  // R3
    '{{3'd2,3'd0,3'd2,5'd1 }, 8'h00, 8'h00, 4'd6 },  // R6 inc wrap
    '{{3'd2,3'd0,3'd2,5'd4 }, 8'h00, 8'hFF, 4'd6 },  // R6 dec wrap
    '{{3'd2,3'd0,3'd2,5'd10}, 8'h00, 8'hFE, 4'd8 },  // R8 msb lost
    '{{3'd3,3'd1,3'd0,5'd31}, 8'h00, 8'h20, 4'd9 },  // R9 unused op
    '{{3'd1,3'd2,3'd0,5'd11}, 8'h00, 8'h08, 4'd9 },  // R9 unused op
    '{{3'd3,3'd3,3'd3,5'd2 }, 8'h00, 8'h40, 4'd10},  // R10 same src/dst
    '{{3'd3,3'd0,3'd0,5'd0 }, 8'h00, 8'h40, 4'd10},  // R10 readback
    '{{3'd0,3'd0,3'd0,5'd2 }, 8'h7F, 8'hFE, 4'd5 },  // R5 ext+ext
    '{{3'd1,3'd0,3'd0,5'd0 }, 8'h00, 8'h08, 4'd3 },  // R3 final R1
    '{{3'd2,3'd0,3'd0,5'd0 }, 8'h00, 8'hFE, 4'd3 },  // R3 final R2
    '{{3'd3,3'd0,3'd0,5'd0 }, 8'h00, 8'h40, 4'd3 },  // R3 final R3
    '{{3'd4,3'd0,3'd0,5'd0 }, 8'h00, 8'h52, 4'd3 },  // R3 final R4
    '{{3'd5,3'd0,3'd0,5'd0 }, 8'h00, 8'hD8, 4'd3 },  // R3 final R5
    '{{3'd6,3'd0,3'd0,5'd0 }, 8'h00, 8'h14, 4'd3 },  // R3 final R6
    '{{3'd7,3'd0,3'd0,5'd0 }, 8'h00, 8'h3D, 4'd3 }   // R3 final R7
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: ext_out=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: ext_out=%h expected=completion", ext_out);
    finish_run();
  end

  initial begin
    // R11: reset state, and a write attempted while reset is held
    repeat (2) @(negedge clk);
    ctrl_word = {3'd0, 3'd0, 3'd4, 5'd0};
    ext_in = 8'h99;
    @(negedge clk);
    for (int k = 1; k <= 7; k++) begin
      ctrl_word = {3'(k), 3'd0, 3'd0, 5'd0};
      #1 check("R11 reset clear", ext_out, 8'h00);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // table of vectors
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ctrl_word = VEC[i].cw;
      ext_in    = VEC[i].din;
      #1 check($sformatf("R%0d row %0d", VEC[i].req, i), ext_out, VEC[i].exp);
    end

    // R5: output follows ext_in within the cycle, no clock edge needed
    @(negedge clk);
    ctrl_word = {3'd0, 3'd0, 3'd0, 5'd0};
    ext_in = 8'h5A;
    #1 check("R5 comb", ext_out, 8'h5A);
    ext_in = 8'hC3;
    #1 check("R5 comb", ext_out, 8'hC3);

    // R1: B field isolated, uses op OR with A=ext 0
    ctrl_word = {3'd0, 3'd4, 3'd0, 5'd6};
    ext_in = 8'h00;
    #1 check("R1 B field", ext_out, 8'h52);

    // R11: asynchronous reset in mid-run clears stored values
    @(negedge clk);
    rst_n = 1'b0;
    ctrl_word = {3'd4, 3'd0, 3'd0, 5'd0};
    #1 check("R11 async clear", ext_out, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    ctrl_word = {3'd7, 3'd0, 3'd0, 5'd0};
    #1 check("R11 after release", ext_out, 8'h00);

    @(negedge clk);
    finish_run();
  end
endmodule